// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

This block is one DMA channel. It moves elements between a device address that never changes and a memory address that steps forward by the element size after every beat. Software starts the channel by writing a mode. In single mode the channel takes its transfer from four register inputs. In chained mode it reads four-word descriptors from memory through a 32-bit read port and follows the link in each one until it reaches a descriptor that ends the chain.

Each descriptor gives a device address, a memory address, a size word and a link word. The size word holds an element-width code and an element count. The two low bits of the link word choose between ending and following, and whether to signal completion. The channel shows a 2-bit activity code, gives a one-cycle completion pulse for each descriptor that asks for one, and gives a one-cycle error pulse when a descriptor is illegal. Writing the off mode stops the channel at any point.

Top module: `dmach_engine`

## Requirements
- R1: After reset, `status_o` is 0 (idle) and `rd_req_o`, `beat_valid_o`, `done_o` and `err_o` are all low.
- R2: A control write with mode 2 (single) while the channel is idle captures the four register inputs. In the next cycle `status_o` is 2 (wait/check). After that one cycle it is 3 (access), or it ends.
- R3: A control write with mode 1 (chained) while the channel is idle first clears the two low bits of `reg_next_i`. It then reads four words at that base +0x0, +0x4, +0x8 and +0xC: device address, memory address, size and link. `status_o` is 1 during these reads, and `rd_req_o` is raised only then, on a 4-byte-aligned address.
- R4: Bits 13:12 of the size word select the element width: 3 gives 1 byte (`beat_lg_o`=0), 2 gives 2 bytes (`beat_lg_o`=1) and 0 gives 4 bytes (`beat_lg_o`=2). Bits 10:0 give the number of beats.
- R5: After each accepted beat the memory address goes up by the element width. The device address stays at the descriptor's value for the whole descriptor.
- R6: The direction input at the start control write (1 = memory to device, 0 = device to memory) is held and shown on `beat_m2d_o` for the whole transfer.
- R7: A descriptor is illegal if its width code is 1, or if its width is 1 or 2 bytes and its count is above 0x3FF. An illegal descriptor produces no beats and one `err_o` pulse, and the channel returns to idle in the same cycle as the pulse.
- R8: Bit 0 of the link word asks for completion. The `done_o` pulse lasts one cycle and comes in the cycle after the descriptor's last beat. Bit 1 asks to follow: the channel then fetches the descriptor at the link address with its two low bits cleared. If bit 1 is clear, the channel goes to idle.
- R9: A descriptor with a count of 0 produces no beats and finishes straight from the check cycle, with completion and linking handled as in R8.
- R10: A control write with mode 0 in any state returns the channel to idle in the next cycle. No further beats or reads follow, and no completion pulse is raised.
- R11: A control write with a nonzero mode while the channel is busy has no effect. The running transfer finishes unchanged.
- R12: Once `rd_req_o` is raised it stays high, with `rd_addr_o` stable, until `rd_valid_i` is seen or the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_mode_i | input | 2 | Mode written: 0 off, 1 chained, 2 single |
| ctl_m2d_i | input | 1 | Direction at start: 1 = memory to device |
| reg_dev_i | input | ADDR_W | Single-mode device address |
| reg_mem_i | input | ADDR_W | Single-mode memory address |
| reg_size_i | input | ADDR_W | Single-mode size word (width code and count) |
| reg_next_i | input | ADDR_W | Link word, or chain base in chained mode |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | ADDR_W | Descriptor word address |
| rd_valid_i | input | 1 | Read data valid, completes the request |
| rd_data_i | input | ADDR_W | Read data |
| beat_valid_o | output | 1 | Beat offered |
| beat_ready_i | input | 1 | Beat accepted |
| beat_mem_addr_o | output | ADDR_W | Memory address of the beat |
| beat_dev_addr_o | output | ADDR_W | Device address of the beat |
| beat_lg_o | output | 2 | log2 of the element bytes |
| beat_m2d_o | output | 1 | Beat direction |
| status_o | output | 2 | 0 idle, 1 descriptor read, 2 wait/check, 3 access |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Illegal-descriptor pulse |

## Verification
The properties assume a well-behaved memory port. It returns exactly one `rd_valid_i` for each pending request cycle and never raises it when no request is pending. The properties also assume that control writes with a nonzero mode, issued while the channel is busy, carry no meaning. The bench drives `rd_valid_i` only as a gated copy of `rd_req_o` and returns data from a small descriptor array indexed by the request address. It applies back-pressure by toggling the read-acknowledge and beat-ready gates on alternate cycles, never by answering an absent request. Control writes appear as single-cycle strobes, and the off mode is used only on purpose, to abort a transfer.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WAIT  = 2'd2,
      ST_MOVE  = 2'd3
   } chan_st_e;

   localparam logic [1:0] MODE_OFF    = 2'd0;
   localparam logic [1:0] MODE_CHAIN  = 2'd1;
   localparam logic [1:0] MODE_SINGLE = 2'd2;

   localparam logic [1:0] WCODE_4B = 2'd0;
   localparam logic [1:0] WCODE_BAD = 2'd1;
   localparam logic [1:0] WCODE_2B = 2'd2;
   localparam logic [1:0] WCODE_1B = 2'd3;

   localparam int WCODE_LSB = 12;

   localparam logic [1:0] WORD_DEV  = 2'd0;
   localparam logic [1:0] WORD_MEM  = 2'd1;
   localparam logic [1:0] WORD_SIZE = 2'd2;
   localparam logic [1:0] WORD_LINK = 2'd3;

endpackage

// File: rtl/dmach_fetch.sv
module dmach_fetch #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   output logic              word_we_o,
   output logic [1:0]        word_idx_o,
   output logic              done_o
);
   localparam logic [1:0] LAST_IDX = 2'd3;

   logic              busy_q;
   logic [1:0]        idx_q;
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         base_q <= '0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         base_q <= base_i;
      end else if (busy_q && rd_valid_i) begin
         idx_q <= idx_q + 2'd1;
         if (idx_q == LAST_IDX) busy_q <= 1'b0;
      end
   end

   assign rd_req_o   = busy_q;
   assign rd_addr_o  = base_q + ADDR_W'({idx_q, 2'b00});
   assign word_we_o  = busy_q && rd_valid_i;
   assign word_idx_o = idx_q;
   assign done_o     = word_we_o && (idx_q == LAST_IDX);

endmodule

// File: rtl/dmach_check.sv
module dmach_check #(
   parameter int CNT_W      = 11,
   parameter int MAX_NARROW = 'h3FF,
   parameter int MAX_WIDE   = 'h7FF
) (
   input  logic [1:0]       wcode_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [1:0]       lg_o,
   output logic             bad_o
);
   import dmach_pkg::*;

   localparam int CNT_FULL = (1 << CNT_W) - 1;

   logic code_bad;
   logic narrow;
   logic narrow_over;
   logic wide_over;

   always_comb begin
      code_bad = 1'b0;
      narrow   = 1'b1;
      unique case (wcode_i)
         WCODE_1B: lg_o = 2'd0;
         WCODE_2B: lg_o = 2'd1;
         WCODE_4B: begin
            lg_o   = 2'd2;
            narrow = 1'b0;
         end
         default: begin
            lg_o     = 2'd0;
            code_bad = 1'b1;
         end
      endcase
   end

   assign narrow_over = narrow && (count_i > CNT_W'(MAX_NARROW));

   generate
      if (MAX_WIDE >= CNT_FULL) begin : g_wide_free
         assign wide_over = 1'b0;
      end else begin : g_wide_limit
         assign wide_over = !narrow && (count_i > CNT_W'(MAX_WIDE));
      end
   endgenerate

   assign bad_o = code_bad || narrow_over || wide_over;

endmodule

// File: rtl/dmach_beat.sv
module dmach_beat #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [1:0]        lg_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        lg_o,
   output logic              last_o
);
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic [1:0]        lg_q;
   logic [ADDR_W-1:0] stride;

   assign stride = ADDR_W'(1) << lg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
         lg_q   <= '0;
      end else if (load_i) begin
         addr_q <= base_i;
         left_q <= count_i;
         lg_q   <= lg_i;
      end else if (step_i) begin
         addr_q <= addr_q + stride;
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign addr_o = addr_q;
   assign lg_o   = lg_q;
   assign last_o = (left_q == CNT_W'(1));

endmodule

// File: rtl/dmach_engine.sv
module dmach_engine #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 11,
   parameter int MAX_NARROW = 'h3FF,
   parameter int MAX_WIDE   = 'h7FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_i,
   input  logic [1:0]        ctl_mode_i,
   input  logic              ctl_m2d_i,
   input  logic [ADDR_W-1:0] reg_dev_i,
   input  logic [ADDR_W-1:0] reg_mem_i,
   input  logic [ADDR_W-1:0] reg_size_i,
   input  logic [ADDR_W-1:0] reg_next_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [ADDR_W-1:0] rd_data_i,
   output logic              beat_valid_o,
   input  logic              beat_ready_i,
   output logic [ADDR_W-1:0] beat_mem_addr_o,
   output logic [ADDR_W-1:0] beat_dev_addr_o,
   output logic [1:0]        beat_lg_o,
   output logic              beat_m2d_o,
   output logic [1:0]        status_o,
   output logic              done_o,
   output logic              err_o
);
   import dmach_pkg::*;

   localparam int WC_HI = WCODE_LSB + 1;

   generate
      if (ADDR_W < WC_HI + 1) begin : g_bad_addr_w
         $error("ADDR_W too narrow for the size word fields");
      end
      if (CNT_W > WCODE_LSB) begin : g_bad_cnt_w
         $error("CNT_W overlaps the width code");
      end
      if (MAX_NARROW > MAX_WIDE) begin : g_bad_limits
         $error("narrow limit above wide limit");
      end
   endgenerate

   chan_st_e          st_q;
   logic [ADDR_W-1:0] dev_q;
   logic [ADDR_W-1:0] mem_q;
   logic [ADDR_W-1:0] link_q;
   logic [1:0]        wcode_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              m2d_q;
   logic              done_q;
   logic              err_q;

   logic              kill;
   logic              go_chain;
   logic              go_single;
   logic              fire;
   logic              last_beat;
   logic              chk_bad;
   logic [1:0]        chk_lg;
   logic              cnt_zero;
   logic              finish;
   logic              follow;
   logic              fetch_start;
   logic [ADDR_W-1:0] fetch_base;
   logic              word_we;
   logic [1:0]        word_idx;
   logic              fetch_done;
   logic              beat_load;
   logic              unused_bits;

   assign kill      = ctl_wr_i && (ctl_mode_i == MODE_OFF);
   assign go_chain  = (st_q == ST_IDLE) && ctl_wr_i && (ctl_mode_i == MODE_CHAIN);
   assign go_single = (st_q == ST_IDLE) && ctl_wr_i && (ctl_mode_i == MODE_SINGLE);
   assign fire      = (st_q == ST_MOVE) && beat_ready_i;
   assign cnt_zero  = (cnt_q == '0);

   assign finish = !kill &&
                   (((st_q == ST_WAIT) && !chk_bad && cnt_zero) || (fire && last_beat));
   assign follow      = finish && link_q[1];
   assign fetch_start = go_chain || follow;
   assign fetch_base  = go_chain ? {reg_next_i[ADDR_W-1:2], 2'b00}
                                 : {link_q[ADDR_W-1:2], 2'b00};
   assign beat_load   = (st_q == ST_WAIT) && !chk_bad && !kill;

   assign unused_bits = ^{reg_size_i, rd_data_i};

   dmach_fetch #(.ADDR_W(ADDR_W)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (fetch_start),
      .abort_i    (kill),
      .base_i     (fetch_base),
      .rd_req_o   (rd_req_o),
      .rd_addr_o  (rd_addr_o),
      .rd_valid_i (rd_valid_i),
      .word_we_o  (word_we),
      .word_idx_o (word_idx),
      .done_o     (fetch_done)
   );

   dmach_check #(
      .CNT_W      (CNT_W),
      .MAX_NARROW (MAX_NARROW),
      .MAX_WIDE   (MAX_WIDE)
   ) u_check (
      .wcode_i (wcode_q),
      .count_i (cnt_q),
      .lg_o    (chk_lg),
      .bad_o   (chk_bad)
   );

   dmach_beat #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_beat (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (beat_load),
      .base_i  (mem_q),
      .count_i (cnt_q),
      .lg_i    (chk_lg),
      .step_i  (fire),
      .addr_o  (beat_mem_addr_o),
      .lg_o    (beat_lg_o),
      .last_o  (last_beat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_q   <= '0;
         mem_q   <= '0;
         link_q  <= '0;
         wcode_q <= '0;
         cnt_q   <= '0;
         m2d_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= finish && link_q[0];
         err_q  <= !kill && (st_q == ST_WAIT) && chk_bad;
         if (go_chain || go_single) m2d_q <= ctl_m2d_i;
         if (go_single) begin
            dev_q   <= reg_dev_i;
            mem_q   <= reg_mem_i;
            wcode_q <= reg_size_i[WC_HI:WCODE_LSB];
            cnt_q   <= reg_size_i[CNT_W-1:0];
            link_q  <= reg_next_i;
         end else if (word_we) begin
            unique case (word_idx)
               WORD_DEV:  dev_q <= rd_data_i;
               WORD_MEM:  mem_q <= rd_data_i;
               WORD_SIZE: begin
                  wcode_q <= rd_data_i[WC_HI:WCODE_LSB];
                  cnt_q   <= rd_data_i[CNT_W-1:0];
               end
               default:   link_q <= rd_data_i;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else if (kill) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (go_chain)       st_q <= ST_FETCH;
               else if (go_single) st_q <= ST_WAIT;
            end
            ST_FETCH: if (fetch_done) st_q <= ST_WAIT;
            ST_WAIT: begin
               if (chk_bad)       st_q <= ST_IDLE;
               else if (cnt_zero) st_q <= link_q[1] ? ST_FETCH : ST_IDLE;
               else               st_q <= ST_MOVE;
            end
            default: begin
               if (fire && last_beat) st_q <= link_q[1] ? ST_FETCH : ST_IDLE;
            end
         endcase
      end
   end

   assign beat_valid_o    = (st_q == ST_MOVE);
   assign beat_dev_addr_o = dev_q;
   assign beat_m2d_o      = m2d_q;
   assign status_o        = st_q;
   assign done_o          = done_q;
   assign err_o           = err_q;

endmodule

// File: rtl/dmach_engine_chk.sv
module dmach_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_wr_i,
   input logic [1:0]        ctl_mode_i,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_valid_i,
   input logic              beat_valid_o,
   input logic              beat_ready_i,
   input logic [ADDR_W-1:0] beat_mem_addr_o,
   input logic [ADDR_W-1:0] beat_dev_addr_o,
   input logic [1:0]        beat_lg_o,
   input logic [1:0]        status_o,
   input logic              done_o,
   input logic              err_o
);
   logic stop_wr;
   assign stop_wr = ctl_wr_i && (ctl_mode_i == 2'd0);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 2'd0) |-> (!rd_req_o && !beat_valid_o));

   a_r3_req_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (status_o == 2'd1));

   a_r3_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (rd_addr_o[1:0] == 2'b00));

   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_valid_i && !stop_wr) |=> (rd_req_o && $stable(rd_addr_o)));

   a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid_o && beat_ready_i && !stop_wr) |=>
      ((status_o != 2'd3) ||
       (beat_mem_addr_o == $past(beat_mem_addr_o) + (ADDR_W'(1) << $past(beat_lg_o)))));

   a_r5_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o == 2'd3) && !stop_wr) |=>
      ((status_o != 2'd3) || ($stable(beat_dev_addr_o) && $stable(beat_lg_o))));

   a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_wr |=> ((status_o == 2'd0) && !done_o));

   a_r7_err_from_check: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (($past(status_o) == 2'd2) && (status_o == 2'd0)));

   a_r8_pulse_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

bind dmach_engine dmach_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ctl_wr_i        (ctl_wr_i),
   .ctl_mode_i      (ctl_mode_i),
   .rd_req_o        (rd_req_o),
   .rd_addr_o       (rd_addr_o),
   .rd_valid_i      (rd_valid_i),
   .beat_valid_o    (beat_valid_o),
   .beat_ready_i    (beat_ready_i),
   .beat_mem_addr_o (beat_mem_addr_o),
   .beat_dev_addr_o (beat_dev_addr_o),
   .beat_lg_o       (beat_lg_o),
   .status_o        (status_o),
   .done_o          (done_o),
   .err_o           (err_o)
);

// File: tb/sim_dmach_engine.sv
`timescale 1ns/1ps
module sim_dmach_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [1:0]  ctl_mode = 2'd0;
   logic        ctl_m2d = 1'b0;
   logic [31:0] reg_dev = '0, reg_mem = '0, reg_size = '0, reg_next = '0;
   logic        rd_req, rd_valid;
   logic [31:0] rd_addr, rd_data;
   logic        beat_valid, beat_m2d, done, err;
   logic        beat_ready = 1'b1;
   logic [31:0] beat_mem, beat_dev;
   logic [1:0]  beat_lg, status;

   logic        stall = 1'b0;
   logic        ack_en = 1'b1;
   logic [31:0] dmem [16];

   int checks = 0;
   int fails = 0;
   int nbeats, ndone, nerr, nreads;
   bit saw_fetch;
   logic [31:0] last_mem, last_dev, first_rd;
   logic [1:0]  last_lg;
   logic        last_m2d;

   always #2.5 clk = ~clk;

   assign rd_valid = rd_req && ack_en;
   assign rd_data  = dmem[rd_addr[5:2]];

   dmach_engine u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .ctl_mode_i(ctl_mode),
      .ctl_m2d_i(ctl_m2d), .reg_dev_i(reg_dev), .reg_mem_i(reg_mem),
      .reg_size_i(reg_size), .reg_next_i(reg_next),
      .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
      .beat_valid_o(beat_valid), .beat_ready_i(beat_ready),
      .beat_mem_addr_o(beat_mem), .beat_dev_addr_o(beat_dev), .beat_lg_o(beat_lg),
      .beat_m2d_o(beat_m2d), .status_o(status), .done_o(done), .err_o(err)
   );

   always @(negedge clk) begin
      beat_ready <= stall ? ~beat_ready : 1'b1;
      ack_en     <= stall ? ~ack_en : 1'b1;
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (beat_valid && beat_ready) begin
            nbeats++;
            last_mem = beat_mem;
            last_dev = beat_dev;
            last_lg  = beat_lg;
            last_m2d = beat_m2d;
         end
         if (rd_valid) begin
            if (nreads == 0) first_rd = rd_addr;
            nreads++;
         end
         if (done) ndone++;
         if (err) nerr++;
         if (status == 2'd1) saw_fetch = 1'b1;
      end
   end

   // one-shot table: size word, link word, direction, stall
   localparam logic [31:0] V_SIZE [8] = '{32'h0000_3005, 32'h0000_2003, 32'h0000_0004,
      32'h0000_1002, 32'h0000_3400, 32'h0000_0400, 32'h0000_23FF, 32'h0000_0000};
   localparam logic [31:0] V_LINK [8] = '{32'h1, 32'h0, 32'h1, 32'h1, 32'h0, 32'h0, 32'h1, 32'h1};
   localparam bit V_DIR [8]   = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
   localparam bit V_STALL [8] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
   localparam logic [31:0] MEM0 = 32'h0000_1000;
   localparam logic [31:0] DEV0 = 32'h4000_0010;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      nbeats = 0; ndone = 0; nerr = 0; nreads = 0; saw_fetch = 1'b0;
      last_mem = '0; last_dev = '0; last_lg = '0; last_m2d = 1'b0; first_rd = '1;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (status != 2'd0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 20000) chk(1'b0, "watchdog: channel never idle", {30'd0, status}, 32'd0);
      repeat (2) @(negedge clk);
   endtask

   task automatic start(input logic [1:0] md, input bit dir,
                        input logic [31:0] sz, input logic [31:0] lk);
      @(negedge clk);
      clear_mon();
      reg_dev = DEV0; reg_mem = MEM0; reg_size = sz; reg_next = lk;
      ctl_mode = md; ctl_m2d = dir; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   initial begin
      #900_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) dmem[i] = '0;
      // chain: A at 0x00 follows to B at 0x10; bad descriptor at 0x20
      dmem[0] = 32'h0000_5000; dmem[1] = 32'h0000_0200;
      dmem[2] = 32'h0000_3003; dmem[3] = 32'h0000_0013;
      dmem[4] = 32'h0000_6000; dmem[5] = 32'h0000_0300;
      dmem[6] = 32'h0000_2002; dmem[7] = 32'h0000_0001;
      dmem[8] = 32'h0000_7000; dmem[9] = 32'h0000_0400;
      dmem[10] = 32'h0000_1003; dmem[11] = 32'h0000_0001;
      clear_mon();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(status == 2'd0, "R1 status after reset", {30'd0, status}, 32'd0);
      chk(!rd_req && !beat_valid, "R1 no request or beat", {30'd0, rd_req, beat_valid}, 32'd0);
      chk(!done && !err, "R1 no pulses", {30'd0, done, err}, 32'd0);

      // table walk: single mode transfers (R2 R4 R5 R6 R7 R8 R9)
      for (int v = 0; v < 8; v++) begin
         logic [1:0]  wc;
         logic [10:0] cnt;
         bit          bad;
         int          lg, exp_beats;
         logic [31:0] exp_last;
         wc  = V_SIZE[v][13:12];
         cnt = V_SIZE[v][10:0];
         bad = (wc == 2'd1) || ((wc != 2'd0) && (cnt > 11'h3FF));
         lg  = (wc == 2'd3) ? 0 : (wc == 2'd2) ? 1 : 2;
         exp_beats = bad ? 0 : int'(cnt);
         exp_last  = MEM0 + ((exp_beats - 1) << lg);
         stall = V_STALL[v];
         start(2'd2, V_DIR[v], V_SIZE[v], V_LINK[v]);
         chk(status == 2'd2, $sformatf("R2 wait code after start v%0d", v), {30'd0, status}, 32'd2);
         wait_idle();
         stall = 1'b0;
         chk(nbeats == exp_beats, $sformatf("R4 R9 beat count v%0d", v), nbeats, exp_beats);
         chk(nerr == int'(bad), $sformatf("R7 error pulses v%0d", v), nerr, int'(bad));
         chk(ndone == int'(!bad && V_LINK[v][0]), $sformatf("R8 done pulses v%0d", v),
             ndone, int'(!bad && V_LINK[v][0]));
         if (exp_beats > 0) begin
            chk(last_mem == exp_last, $sformatf("R5 last memory address v%0d", v), last_mem, exp_last);
            chk(last_dev == DEV0, $sformatf("R5 device address v%0d", v), last_dev, DEV0);
            chk(last_lg == 2'(lg), $sformatf("R4 width v%0d", v), {30'd0, last_lg}, lg);
            chk(last_m2d == V_DIR[v], $sformatf("R6 direction v%0d", v), last_m2d, V_DIR[v]);
         end
      end

      // R3 R8 chained pair with read stalls
      stall = 1'b1;
      start(2'd1, 1'b1, 32'h0, 32'h0000_0002);
      chk(status == 2'd1, "R3 fetch code after chain start", {30'd0, status}, 32'd1);
      wait_idle();
      stall = 1'b0;
      chk(first_rd == 32'h0, "R3 first read address low bits cleared", first_rd, 32'h0);
      chk(nreads == 8, "R3 R8 descriptor words read", nreads, 8);
      chk(nbeats == 5, "R8 beats across chain", nbeats, 5);
      chk(ndone == 2, "R8 done per descriptor", ndone, 2);
      chk(last_mem == 32'h0000_0302, "R5 chain last memory address", last_mem, 32'h302);
      chk(last_dev == 32'h0000_6000, "R5 chain second device address", last_dev, 32'h6000);
      chk(last_m2d == 1'b1, "R6 chain direction", last_m2d, 1'b1);

      // R7 illegal descriptor fetched from memory
      start(2'd1, 1'b0, 32'h0, 32'h0000_0020);
      wait_idle();
      chk(nerr == 1 && nbeats == 0, "R7 chained bad width code", nerr * 16 + nbeats, 16);
      chk(status == 2'd0 && ndone == 0, "R7 idle without done", ndone, 0);

      // R10 abort mid transfer
      begin
         int nb;
         start(2'd2, 1'b0, 32'h0000_0064, 32'h1);
         repeat (10) @(negedge clk);
         ctl_mode = 2'd0; ctl_wr = 1'b1;
         @(negedge clk);
         ctl_wr = 1'b0;
         chk(status == 2'd0, "R10 idle after stop", {30'd0, status}, 32'd0);
         chk(!beat_valid, "R10 no beat after stop", beat_valid, 1'b0);
         nb = nbeats;
         repeat (5) @(negedge clk);
         chk(nbeats == nb && nb > 0 && nb < 100, "R10 beats frozen", nbeats, nb);
         chk(ndone == 0, "R10 no completion", ndone, 0);
      end

      // R11 nonzero mode write while busy is ignored
      start(2'd2, 1'b0, 32'h0000_3014, 32'h1);
      repeat (3) @(negedge clk);
      reg_next = 32'h0000_0020; ctl_mode = 2'd1; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
      wait_idle();
      chk(nbeats == 20, "R11 transfer unchanged", nbeats, 20);
      chk(!saw_fetch && nerr == 0 && ndone == 1, "R11 no fetch or error", nerr, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule